// File: doc/BRIEF.md
# Packet Buffer Byte Access Port

This block lets a host reach individual bytes of the packet buffers through a small register window. A 16-bit pointer register, written and read as two byte registers, holds a byte offset inside one 2048-byte buffer, a flag that picks which buffer is addressed, and a flag that turns on auto-increment. A four-byte data window then reads or writes the buffer byte that the pointer names. The buffer is either the one at the head of the receive queue or the one named by the packet-number register. Both of those values come in as inputs from the allocation logic.

A host access is one, two or four bytes wide. The block splits it into single-byte operations and runs them one per clock in ascending byte order. A pointer write made early in an access therefore steers the data bytes later in the same access. Toward the buffer memory the block drives a 13-bit byte address with separate read and write strobes. It expects read data one cycle after a read strobe.

Top module: `pdp_port`

## Requirements
- R1: After reset the pointer is 0x0000, host_busy and host_done are low, and neither memory strobe is active.
- R2: host_size 0 moves 1 byte, 1 moves 2 bytes, and 2 or 3 move 4 bytes. Byte i of an access goes to window offset (host_ofs + i) mod 16. Bytes are handled one per cycle in ascending i. Byte i is taken from host_wdata bits 8i+7:8i and returned in host_rdata bits 8i+7:8i. Unused rdata bytes read as zero.
- R3: Window offset 6 is pointer bits 7:0 and offset 7 is pointer bits 15:8. A write stores the whole byte.
- R4: A read of offset 6 returns pointer bits 7:0 unchanged. A read of offset 7 returns pointer bits 15:8 ANDed with 0xF7.
- R5: Pointer bit 15 set selects rx_head as the buffer index, and clear selects pkt_num. mem_addr is {buffer index, 11-bit byte offset}.
- R6: With pointer bit 14 clear, a data byte at window offset 8+k (k = 0..3) uses offset (pointer bits 10:0 + k) mod 2048. The pointer is left unchanged.
- R7: With pointer bit 14 set, a data byte uses pointer bits 10:0 directly, whatever its window offset. Afterwards bits 10:0 advance by one mod 2048 and bits 15:11 keep their value.
- R8: A data-window read byte drives mem_rd for exactly one cycle, and a write byte drives mem_wr with mem_wdata. The byte on mem_rdata in the next cycle is what is returned. Strobes occur only while host_busy is high.
- R9: After a request is accepted, host_busy is high for N+1 cycles (N = bytes moved). host_done then pulses for one cycle with host_busy low and host_rdata valid. Requests presented while host_busy is high are ignored.
- R10: Window offsets 0-5 and 12-15 cause no memory strobe and no pointer change, and they read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Access request, taken when host_busy is low |
| host_write | input | 1 | 1 = write, 0 = read |
| host_ofs | input | 4 | Window offset of the first byte |
| host_size | input | 2 | 0 = byte, 1 = 16-bit, 2/3 = 32-bit |
| host_wdata | input | 32 | Write data, byte i in bits 8i+7:8i |
| host_busy | output | 1 | Access in progress |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read result, valid with host_done |
| pkt_num | input | 2 | Buffer index from the packet-number register |
| rx_head | input | 2 | Buffer index at the head of the receive queue |
| mem_addr | output | 13 | Buffer byte address |
| mem_rd | output | 1 | Buffer read strobe |
| mem_wr | output | 1 | Buffer write strobe |
| mem_wdata | output | 8 | Buffer write byte |
| mem_rdata | input | 8 | Buffer read byte, one cycle after mem_rd |

## Verification
The request is sampled at edge 0. Byte i is then issued in cycle i+1, so the bench compares the memory strobes, address and write byte of every byte in that cycle. host_busy must be high in cycles 1 to N+1, and host_done must be high only in cycle N+2, where host_rdata is compared. The reference model walks the same byte order on its own pointer and a shadow memory, so pointer effects inside one access are predicted before the access starts. Pointer state is confirmed only by reading it back through offsets 6 and 7.

// File: rtl/pdp_pkg.sv
package pdp_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WALT = 2'd3
    } acc_size_e;

    // One byte-sized step of a host access
    typedef struct packed {
        logic       valid;
        logic       write;
        logic [3:0] ofs;
        logic [1:0] idx;
        logic       last;
        logic [7:0] wdata;
    } byte_op_t;

    function automatic logic [1:0] final_index(input logic [1:0] sz);
        case (acc_size_e'(sz))
            SZ_BYTE: return 2'd0;
            SZ_HALF: return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/pdp_seq.sv
module pdp_seq
    import pdp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [3:0]  req_ofs,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_wdata,
    input  logic        hold,
    output logic        active,
    output logic        start,
    output byte_op_t    op
);

    typedef struct packed {
        logic        active;
        logic        write;
        logic [3:0]  base;
        logic [1:0]  idx;
        logic [1:0]  last;
        logic [31:0] wdata;
    } seq_st_t;

    seq_st_t q, d;

    always_comb begin
        d     = q;
        start = req_valid && !q.active && !hold;
        if (start) begin
            d.active = 1'b1;
            d.write  = req_write;
            d.base   = req_ofs;
            d.idx    = 2'd0;
            d.last   = final_index(req_size);
            d.wdata  = req_wdata;
        end else if (q.active) begin
            if (q.idx == q.last) d.active = 1'b0;
            else                 d.idx    = q.idx + 2'd1;
        end
        op.valid = q.active;
        op.write = q.write;
        op.ofs   = q.base + {2'b00, q.idx};
        op.idx   = q.idx;
        op.last  = (q.idx == q.last);
        op.wdata = q.wdata[{q.idx, 3'b000} +: 8];
        active   = q.active;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // A request arriving mid-access must not disturb the captured one
    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && req_valid) |=> ($stable(q.base) && $stable(q.wdata) && $stable(q.last)));

endmodule

// File: rtl/pdp_ptr.sv
module pdp_ptr #(
    parameter int NUM_BUFS   = 4,
    parameter int BUF_BYTES  = 2048,
    parameter int PTR_LO_OFS = 6,
    parameter int PTR_HI_OFS = 7,
    parameter int WIN_BASE   = 8,
    localparam int OFS_W     = $clog2(BUF_BYTES),
    localparam int IDX_W     = $clog2(NUM_BUFS),
    localparam int MEM_AW    = IDX_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_write,
    input  logic [3:0]        op_ofs,
    input  logic [7:0]        op_wdata,
    input  logic [IDX_W-1:0]  pkt_num,
    input  logic [IDX_W-1:0]  rx_head,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [7:0]        mem_wdata,
    output logic              mem_read_byte,
    output logic [7:0]        reg_val
);

    localparam int         SRC_BIT = 15;
    localparam int         INC_BIT = 14;
    localparam logic [7:0] HI_MASK = 8'hF7;

    typedef struct packed {
        logic [15:0] ptr;
    } ptr_st_t;

    ptr_st_t q, d;

    logic             in_win, is_lo, is_hi;
    logic [1:0]       lane;
    logic [OFS_W-1:0] cur_ofs, sel_ofs;
    logic [IDX_W-1:0] buf_sel;

    always_comb begin
        d       = q;
        in_win  = (int'(op_ofs) >= WIN_BASE) && (int'(op_ofs) < WIN_BASE + 4);
        is_lo   = (int'(op_ofs) == PTR_LO_OFS);
        is_hi   = (int'(op_ofs) == PTR_HI_OFS);
        lane    = op_ofs[1:0] - 2'(WIN_BASE);
        cur_ofs = q.ptr[OFS_W-1:0];
        sel_ofs = q.ptr[INC_BIT] ? cur_ofs : cur_ofs + OFS_W'(lane);
        buf_sel = q.ptr[SRC_BIT] ? rx_head : pkt_num;
        if (op_valid) begin
            if (op_write && is_lo)
                d.ptr[7:0] = op_wdata;
            else if (op_write && is_hi)
                d.ptr[15:8] = op_wdata;
            else if (in_win && q.ptr[INC_BIT])
                d.ptr[OFS_W-1:0] = cur_ofs + OFS_W'(1);
        end
        if (is_lo)      reg_val = q.ptr[7:0];
        else if (is_hi) reg_val = q.ptr[15:8] & HI_MASK;
        else            reg_val = 8'h00;
        mem_addr      = {buf_sel, sel_ofs};
        mem_rd        = op_valid && in_win && !op_write;
        mem_wr        = op_valid && in_win && op_write;
        mem_wdata     = op_wdata;
        mem_read_byte = mem_rd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assert_autoinc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && in_win && q.ptr[INC_BIT]) |=>
        (q.ptr[OFS_W-1:0] == OFS_W'($past(q.ptr[OFS_W-1:0]) + 1) && $stable(q.ptr[15:OFS_W])));

    assert_plain_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && in_win && !q.ptr[INC_BIT]) |=> $stable(q.ptr));

    assert_other_ofs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !in_win && !is_lo && !is_hi) |=> $stable(q.ptr));

endmodule

// File: rtl/pdp_rdcol.sv
module pdp_rdcol (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        op_valid,
    input  logic        op_write,
    input  logic [1:0]  op_idx,
    input  logic        op_last,
    input  logic        from_mem,
    input  logic [7:0]  reg_val,
    input  logic [7:0]  mem_rdata,
    output logic        pending,
    output logic        done,
    output logic [31:0] rdata
);

    typedef struct packed {
        logic        pend_v;
        logic        pend_wr;
        logic [1:0]  pend_idx;
        logic        pend_last;
        logic        pend_mem;
        logic [7:0]  pend_val;
        logic [31:0] rbuf;
        logic        done;
    } col_st_t;

    col_st_t q, d;

    always_comb begin
        d      = q;
        d.done = q.pend_v && q.pend_last;
        if (start) d.rbuf = '0;
        if (q.pend_v && !q.pend_wr)
            d.rbuf[{q.pend_idx, 3'b000} +: 8] = q.pend_mem ? mem_rdata : q.pend_val;
        d.pend_v    = op_valid;
        d.pend_wr   = op_write;
        d.pend_idx  = op_idx;
        d.pend_last = op_last;
        d.pend_mem  = from_mem;
        d.pend_val  = reg_val;
        pending     = q.pend_v;
        done        = q.done;
        rdata       = q.rbuf;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/pdp_port.sv
module pdp_port
    import pdp_pkg::*;
#(
    parameter int NUM_BUFS   = 4,
    parameter int BUF_BYTES  = 2048,
    parameter int PTR_LO_OFS = 6,
    parameter int PTR_HI_OFS = 7,
    parameter int WIN_BASE   = 8,
    localparam int OFS_W     = $clog2(BUF_BYTES),
    localparam int IDX_W     = $clog2(NUM_BUFS),
    localparam int MEM_AW    = IDX_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic              host_write,
    input  logic [3:0]        host_ofs,
    input  logic [1:0]        host_size,
    input  logic [31:0]       host_wdata,
    output logic              host_busy,
    output logic              host_done,
    output logic [31:0]       host_rdata,
    input  logic [IDX_W-1:0]  pkt_num,
    input  logic [IDX_W-1:0]  rx_head,
    output logic [MEM_AW-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);

    byte_op_t   op;
    logic       seq_active, seq_start, col_pending, read_byte;
    logic [7:0] reg_val;

    pdp_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (host_valid),
        .req_write (host_write),
        .req_ofs   (host_ofs),
        .req_size  (host_size),
        .req_wdata (host_wdata),
        .hold      (col_pending),
        .active    (seq_active),
        .start     (seq_start),
        .op        (op)
    );

    pdp_ptr #(
        .NUM_BUFS   (NUM_BUFS),
        .BUF_BYTES  (BUF_BYTES),
        .PTR_LO_OFS (PTR_LO_OFS),
        .PTR_HI_OFS (PTR_HI_OFS),
        .WIN_BASE   (WIN_BASE)
    ) u_ptr (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_valid      (op.valid),
        .op_write      (op.write),
        .op_ofs        (op.ofs),
        .op_wdata      (op.wdata),
        .pkt_num       (pkt_num),
        .rx_head       (rx_head),
        .mem_addr      (mem_addr),
        .mem_rd        (mem_rd),
        .mem_wr        (mem_wr),
        .mem_wdata     (mem_wdata),
        .mem_read_byte (read_byte),
        .reg_val       (reg_val)
    );

    pdp_rdcol u_col (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (seq_start),
        .op_valid  (op.valid),
        .op_write  (op.write),
        .op_idx    (op.idx),
        .op_last   (op.last),
        .from_mem  (read_byte),
        .reg_val   (reg_val),
        .mem_rdata (mem_rdata),
        .pending   (col_pending),
        .done      (host_done),
        .rdata     (host_rdata)
    );

    assign host_busy = seq_active | col_pending;

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |-> !host_busy);

    assert_strobe_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> host_busy);

    assert_read_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (host_busy && !host_done));

endmodule

// File: tb/pdp_port_bench.sv
`timescale 1ns/1ps
module pdp_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic        host_write = 1'b0;
    logic [3:0]  host_ofs = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic        host_busy, host_done;
    logic [31:0] host_rdata;
    logic [1:0]  pkt_num = '0;
    logic [1:0]  rx_head = '0;
    logic [12:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    // reference model state
    int mptr = 0;
    int rmem[int];
    int bmem[int];

    always #2.5 clk = ~clk;

    pdp_port u_pdp_port (
        .clk(clk), .rst_n(rst_n),
        .host_valid(host_valid), .host_write(host_write), .host_ofs(host_ofs),
        .host_size(host_size), .host_wdata(host_wdata),
        .host_busy(host_busy), .host_done(host_done), .host_rdata(host_rdata),
        .pkt_num(pkt_num), .rx_head(rx_head),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic int fill(input int a);
        return (a * 29 + 7) & 255;
    endfunction

    // buffer memory environment with one-cycle registered read
    always @(posedge clk) begin
        if (mem_wr) bmem[int'(mem_addr)] = int'(mem_wdata);
        if (mem_rd) mem_rdata <= 8'(bmem.exists(int'(mem_addr)) ? bmem[int'(mem_addr)] : fill(int'(mem_addr)));
    end

    function automatic int rget(input int a);
        return rmem.exists(a) ? rmem[a] : fill(a);
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic set_src(input int pn, input int rh);
        @(negedge clk);
        pkt_num = 2'(pn);
        rx_head = 2'(rh);
    endtask

    task automatic access(input bit wr, input int ofs, input int sz, input logic [31:0] wd,
                          input int hold, input string req);
        int nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        int ek[4];
        int ea[4];
        int ew[4];
        logic [31:0] erd = '0;
        for (int i = 0; i < nb; i++) begin
            int a = (ofs + i) & 15;
            int b = int'((wd >> (8 * i)) & 32'hFF);
            ek[i] = 0; ea[i] = 0; ew[i] = 0;
            if (a == 6) begin
                if (wr) mptr = (mptr & 'hFF00) | b;
                else    erd[8*i +: 8] = 8'(mptr & 255);
            end else if (a == 7) begin
                if (wr) mptr = (mptr & 'h00FF) | (b << 8);
                else    erd[8*i +: 8] = 8'((mptr >> 8) & 'hF7);
            end else if (a >= 8 && a <= 11) begin
                int bsel = ((mptr & 'h8000) != 0) ? int'(rx_head) : int'(pkt_num);
                int o = ((mptr & 'h4000) != 0) ? (mptr & 'h7FF) : ((mptr + (a - 8)) & 'h7FF);
                ea[i] = bsel * 2048 + o;
                ek[i] = wr ? 2 : 1;
                ew[i] = b;
                if (wr) rmem[ea[i]] = b;
                else    erd[8*i +: 8] = 8'(rget(ea[i]));
                if ((mptr & 'h4000) != 0) mptr = (mptr & 'hF800) | ((mptr + 1) & 'h7FF);
            end
        end
        @(negedge clk);
        host_valid = 1'b1; host_write = wr; host_ofs = 4'(ofs);
        host_size = 2'(sz); host_wdata = wd;
        for (int k = 1; k <= nb + 2; k++) begin
            @(negedge clk);
            if (k > hold) host_valid = 1'b0;
            else begin
                // disturbing request while busy: must be ignored (R9)
                host_write = 1'b1; host_ofs = 4'd6; host_size = 2'd1; host_wdata = 32'hFFFF_FFFF;
            end
            check("R9", "busy", 32'(host_busy), 32'(k <= nb + 1));
            check("R9", "done", 32'(host_done), 32'(k == nb + 2));
            if (k <= nb) begin
                check("R8", "mem_rd", 32'(mem_rd), 32'(ek[k-1] == 1));
                check("R8", "mem_wr", 32'(mem_wr), 32'(ek[k-1] == 2));
                if (ek[k-1] != 0) check(req, "mem_addr", 32'(mem_addr), 32'(ea[k-1]));
                if (ek[k-1] == 2) check(req, "mem_wdata", 32'(mem_wdata), 32'(ew[k-1]));
            end else begin
                check("R8", "strobe idle", 32'({mem_rd, mem_wr}), 32'd0);
            end
            if (k == nb + 2 && !wr) check(req, "rdata", host_rdata, erd);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "busy", 32'(host_busy), 32'd0);
        check("R1", "done", 32'(host_done), 32'd0);
        check("R1", "strobes", 32'({mem_rd, mem_wr}), 32'd0);
        access(0, 6, 1, 0, 0, "R1");

        // R3: pointer bytes written as a 16-bit access, read back
        access(1, 6, 1, 32'h0000_0123, 0, "R3");
        access(0, 6, 1, 0, 0, "R3");

        // R4: high byte read masks bit 11
        access(1, 7, 0, 32'h0000_000F, 0, "R4");
        access(0, 7, 0, 0, 0, "R4");
        access(0, 6, 1, 0, 0, "R4");

        // R6 / R2: plain offset, lane adds, 32-bit write then read
        set_src(2, 1);
        access(1, 6, 1, 32'h0000_0010, 0, "R6");
        access(1, 8, 2, 32'hA1B2_C3D4, 0, "R6");
        access(0, 8, 2, 0, 0, "R6");
        access(0, 6, 1, 0, 0, "R6");
        access(0, 10, 1, 0, 0, "R2");

        // R5: receive-queue head as source
        access(1, 6, 1, 32'h0000_8010, 0, "R5");
        access(0, 8, 3, 0, 0, "R5");
        set_src(3, 0);
        access(0, 9, 0, 0, 0, "R5");

        // R7: auto-increment with wrap, lane ignored
        set_src(2, 1);
        access(1, 6, 1, 32'h0000_47FE, 0, "R7");
        access(1, 8, 2, 32'h1122_3344, 0, "R7");
        access(0, 6, 1, 0, 0, "R7");
        access(1, 6, 1, 32'h0000_47FE, 0, "R7");
        access(0, 10, 1, 0, 0, "R7");
        access(0, 11, 2, 32'h0, 0, "R7");
        access(0, 6, 1, 0, 0, "R7");

        // R6: offset plus lane wraps within the buffer
        access(1, 6, 1, 32'h0000_07FF, 0, "R6");
        access(0, 11, 0, 0, 0, "R6");

        // R10: ignored offsets
        access(1, 0, 2, 32'hDEAD_BEEF, 0, "R10");
        access(1, 12, 1, 32'h0000_5555, 0, "R10");
        access(0, 12, 2, 0, 0, "R10");
        access(0, 2, 2, 0, 0, "R10");
        access(0, 6, 1, 0, 0, "R10");

        // R2: pointer written inside the same access steers the data bytes
        access(1, 6, 2, 32'h5A6B_4020, 0, "R2");
        access(0, 6, 2, 0, 0, "R2");
        access(0, 6, 1, 0, 0, "R2");

        // R9: requests held during busy are ignored
        access(1, 8, 2, 32'h0102_0304, 3, "R9");
        access(0, 6, 1, 0, 0, "R9");
        access(0, 7, 0, 0, 2, "R9");
        access(0, 6, 1, 0, 0, "R9");

        repeat (3) @(negedge clk);
        if (!ended) begin
            ended = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule